// File: doc/BRIEF.md
# Peer-Linked Read-Once Secret Bank

The block stores an array of secrets, each of which can be released exactly once. A requester issues a read with three pieces of access metadata (basis, phase and tag). If the addressed cell is still armed and all three fields equal the values loaded with the secret, the secret comes back and the cell is spent at once. Any read of an armed cell whose metadata does not match is treated as tampering: it spends the cell too and returns noise. Every spent cell answers later reads with words taken from one shared pseudo-random entropy source, a 32-bit LFSR that advances every clock.

Cells can be tied into peer groups through a small group number per cell. When any member of a nonzero group is spent, every other member of that group is spent on the following clock, so a whole key set is retired together. An init operation loads a new secret and metadata into one cell and re-arms only that cell. A status operation returns the spent flags of 32 cells at a time.

Requests arrive on a valid/ready channel and each accepted request produces exactly one response on a second valid/ready channel, one clock later. `req_ready` is high whenever the response register is empty or is being drained in the same cycle (`!rsp_valid || rsp_ready`). A response that is not taken stays stable and blocks new requests until `rsp_ready` rises.

Top module: `rob_bank`

## Requirements
- R1: After reset every cell is spent, every group number is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: An init request (`req_op` = 1) loads `req_wdata` as the secret and basis, phase and tag as the cell's metadata, and leaves the cell armed.
- R3: A read (`req_op` = 0) of an armed cell whose basis, phase and tag all match returns the secret with `rsp_released` = 1 and spends the cell.
- R4: A read of a spent cell returns `rsp_released` = 0 and a word from the shared entropy source; two such words from different cycles differ, and neither equals the stored secret.
- R5: A read of an armed cell with any metadata field different returns `rsp_released` = 0 with entropy data and spends the cell.
- R6: A group request (`req_op` = 2) sets the cell's group number to `req_wdata[3:0]`; when a cell with nonzero group g is spent by a read, every cell with group g is spent on the next clock, and cells in group 0 never affect others.
- R7: A read of a peer accepted on the clock right after the triggering collapse already sees the peer as spent.
- R8: Init of one peer re-arms only that cell and leaves the spent state of its peers unchanged, even when it lands on the same clock as a group collapse that covers it.
- R9: A status request (`req_op` = 3) returns word w = `req_addr[4:0]` where bit i is 1 when cell 32*w+i is spent (including collapses due on that clock).
- R10: Each accepted request yields one response on the next clock; `req_ready` equals `!rsp_valid || rsp_ready`, and a stalled response holds its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this clock when valid |
| req_op | input | 2 | 0 read, 1 init, 2 group, 3 status |
| req_addr | input | 10 | Cell index, or status word index in bits [4:0] |
| req_wdata | input | 32 | Secret for init, group number in [3:0] for group |
| req_basis | input | 2 | Basis field for read or init |
| req_phase | input | 2 | Phase field for read or init |
| req_tag | input | 4 | Tag field for read or init |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed on this clock when valid |
| rsp_data | output | 32 | Secret, entropy word, status word, or 0 |
| rsp_released | output | 1 | 1 when rsp_data carries a released secret |

## Verification
On every cycle the assertions check that a read of an armed cell leaves it spent, that an init leaves its cell armed, that at most one group collapse is pending, that the entropy register never sticks at zero, and that a stalled response holds. The group-wide spread, the view of a peer one clock after its trigger, the precedence of init over a same-clock group collapse, and the layout of the status words are shown only by the bench's directed and random scenarios against its own model of the bank.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int BASIS_W = 2;
  localparam int PHASE_W = 2;
  localparam int TAG_W   = 4;

  typedef struct packed {
    logic [BASIS_W-1:0] basis;
    logic [PHASE_W-1:0] phase;
    logic [TAG_W-1:0]   tag;
  } meta_t;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_INIT   = 2'd1,
    OP_GROUP  = 2'd2,
    OP_STATUS = 2'd3
  } op_e;
endpackage

// File: rtl/rob_entropy.sv
module rob_entropy #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = 32'h8020_0003,
  parameter logic [W-1:0] SEED = 32'h1D87_2B41
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] word
);
  logic [W-1:0] lfsr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= SEED;
    else        lfsr <= {1'b0, lfsr[W-1:1]} ^ (lfsr[0] ? TAPS : '0);
  end

  assign word = lfsr;

  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) lfsr != '0);
endmodule

// File: rtl/rob_peer_link.sv
module rob_peer_link #(
  parameter int GRP_W = 4,
  localparam int NGRP = 1 << GRP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [GRP_W-1:0] trig_grp,
  output logic [NGRP-1:0]  pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else begin
      pend <= '0;
      if (trig && trig_grp != '0) pend[trig_grp] <= 1'b1;
    end
  end

  // R6
  one_group_pending_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pend));
endmodule

// File: rtl/rob_cell_array.sv
module rob_cell_array #(
  parameter int N      = 1024,
  parameter int DATA_W = 32,
  parameter int GRP_W  = 4,
  localparam int ADDR_W = $clog2(N),
  localparam int NGRP   = 1 << GRP_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_we,
  input  logic                grp_we,
  input  logic                kill,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  rob_pkg::meta_t      wmeta,
  input  logic [GRP_W-1:0]    wgrp,
  input  logic [NGRP-1:0]     pend,
  output logic [N-1:0]        dead,
  output logic [DATA_W-1:0]   sel_secret,
  output rob_pkg::meta_t      sel_meta,
  output logic [GRP_W-1:0]    sel_grp
);
  logic [DATA_W-1:0] secret [N];
  rob_pkg::meta_t    meta   [N];
  logic [GRP_W-1:0]  grp    [N];
  logic [N-1:0]      coll;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coll <= '1;
      for (int i = 0; i < N; i++) grp[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (grp[i] != '0 && pend[grp[i]]) coll[i] <= 1'b1;
        if (addr == ADDR_W'(i)) begin
          if (init_we) coll[i] <= 1'b0;
          if (kill)    coll[i] <= 1'b1;
          if (grp_we)  grp[i]  <= wgrp;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (init_we) begin
      secret[addr] <= wdata;
      meta[addr]   <= wmeta;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_dead
    assign dead[g] = coll[g] | ((grp[g] != '0) & pend[grp[g]]);
  end

  assign sel_secret = secret[addr];
  assign sel_meta   = meta[addr];
  assign sel_grp    = grp[addr];

  // R2
  init_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_we |=> !coll[$past(addr)]);
endmodule

// File: rtl/rob_bank.sv
module rob_bank #(
  parameter int N      = 1024,
  parameter int DATA_W = 32,
  parameter int GRP_W  = 4,
  localparam int ADDR_W = $clog2(N),
  localparam int SWORDS = N / 32,
  localparam int WIDX_W = (SWORDS > 1) ? $clog2(SWORDS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [1:0]                  req_op,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  input  logic [rob_pkg::BASIS_W-1:0] req_basis,
  input  logic [rob_pkg::PHASE_W-1:0] req_phase,
  input  logic [rob_pkg::TAG_W-1:0]   req_tag,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [DATA_W-1:0]           rsp_data,
  output logic                        rsp_released
);
  import rob_pkg::*;

  localparam int NGRP = 1 << GRP_W;

  op_e                op;
  logic               accept, is_read, armed, match, hit, release_ok;
  meta_t              req_meta, sel_meta;
  logic [DATA_W-1:0]  sel_secret, noise, nxt_data;
  logic [GRP_W-1:0]   sel_grp;
  logic [NGRP-1:0]    pend;
  logic [N-1:0]       dead;
  logic [WIDX_W-1:0]  widx;

  assign op        = op_e'(req_op);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign req_meta  = '{basis: req_basis, phase: req_phase, tag: req_tag};
  assign is_read   = accept && op == OP_READ;
  assign armed     = !dead[req_addr];
  assign match     = sel_meta == req_meta;
  assign hit       = is_read && armed;
  assign release_ok = hit && match;
  assign widx      = req_addr[WIDX_W-1:0];

  rob_entropy #(.W(DATA_W)) entropy_i (
    .clk(clk), .rst_n(rst_n), .word(noise)
  );

  rob_peer_link #(.GRP_W(GRP_W)) link_i (
    .clk(clk), .rst_n(rst_n), .trig(hit), .trig_grp(sel_grp), .pend(pend)
  );

  rob_cell_array #(.N(N), .DATA_W(DATA_W), .GRP_W(GRP_W)) cells_i (
    .clk(clk), .rst_n(rst_n),
    .init_we(accept && op == OP_INIT),
    .grp_we(accept && op == OP_GROUP),
    .kill(hit),
    .addr(req_addr), .wdata(req_wdata), .wmeta(req_meta),
    .wgrp(req_wdata[GRP_W-1:0]), .pend(pend),
    .dead(dead), .sel_secret(sel_secret), .sel_meta(sel_meta), .sel_grp(sel_grp)
  );

  always_comb begin
    unique case (op)
      OP_READ:   nxt_data = release_ok ? sel_secret : noise;
      OP_STATUS: nxt_data = DATA_W'(dead[32*widx +: 32]);
      default:   nxt_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_released <= 1'b0;
    end else if (accept) begin
      rsp_valid    <= 1'b1;
      rsp_data     <= nxt_data;
      rsp_released <= release_ok;
    end else if (rsp_ready) begin
      rsp_valid    <= 1'b0;
    end
  end

  // R3
  collapse_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> dead[$past(req_addr)]);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_released));
endmodule

// File: tb/rob_bank_tb.sv
module rob_bank_tb_top;
  localparam int N = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_op = '0;
  logic [9:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_basis = '0, req_phase = '0;
  logic [3:0]  req_tag = '0;
  logic        rsp_valid, rsp_ready = 1'b1, rsp_released;
  logic [31:0] rsp_data;

  always #4 clk = ~clk;

  rob_bank dut_i (.*);

  int tests = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_sec [N];
  logic [7:0]  m_meta [N];
  logic [3:0]  m_grp [N];
  bit          m_dead [N];
  logic [3:0]  m_pend = '0;
  logic [31:0] last_obf = '0;
  bit          have_obf = 0;
  logic [31:0] got_data;
  logic        got_rel, got_valid;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status(input int w);
    logic [31:0] v;
    for (int i = 0; i < 32; i++) v[i] = m_dead[32*w+i];
    return v;
  endfunction

  function automatic void apply_pend();
    if (m_pend != 0)
      for (int i = 0; i < N; i++) if (m_grp[i] == m_pend) m_dead[i] = 1;
    m_pend = 0;
  endfunction

  task automatic issue(input logic [1:0] op, input int a, input logic [31:0] wd, input logic [7:0] md);
    req_valid = 1; req_op = op; req_addr = 10'(a); req_wdata = wd;
    {req_basis, req_phase, req_tag} = md;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    got_data = rsp_data; got_rel = rsp_released; got_valid = rsp_valid;
  endtask

  task automatic idle();
    apply_pend();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_op(input logic [1:0] op, input int a, input logic [31:0] wd, input logic [7:0] md, input string tag);
    bit armed, exp_rel;
    apply_pend();
    armed = !m_dead[a];
    exp_rel = armed && (md == m_meta[a]);
    issue(op, a, wd, md);
    check(got_valid === 1'b1, {tag, " R10 latency"}, 32'(got_valid), 1);
    case (op)
      2'd0: begin
        check(got_rel === exp_rel, {tag, " released"}, 32'(got_rel), 32'(exp_rel));
        if (exp_rel) check(got_data === m_sec[a], {tag, " R3 secret"}, got_data, m_sec[a]);
        else begin
          if (armed) check(got_data !== m_sec[a], {tag, " R5 noise"}, got_data, m_sec[a]);
          if (have_obf) check(got_data !== last_obf, {tag, " R4 fresh noise"}, got_data, last_obf);
          last_obf = got_data; have_obf = 1;
        end
        if (armed) begin
          m_dead[a] = 1;
          m_pend = m_grp[a];
        end
      end
      2'd1: begin
        check(got_data === 0, {tag, " R2 ack"}, got_data, 0);
        m_sec[a] = wd; m_meta[a] = md; m_dead[a] = 0;
      end
      2'd2: begin
        check(got_data === 0, {tag, " R6 ack"}, got_data, 0);
        m_grp[a] = wd[3:0];
      end
      default: check(got_data === exp_status(a % 32), {tag, " R9 status"}, got_data, exp_status(a % 32));
    endcase
  endtask

  task automatic bp_test();
    logic [31:0] held;
    apply_pend();
    rsp_ready = 0;
    issue(2'd3, 0, 0, 0);
    check(req_ready === 1'b0, "R10 ready low when stalled", 32'(req_ready), 0);
    held = rsp_data;
    req_valid = 1; req_op = 2'd3; req_addr = 10'd1;
    @(posedge clk); @(negedge clk);
    check(rsp_valid === 1'b1 && rsp_data === held, "R10 held data", rsp_data, held);
    rsp_ready = 1;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check(rsp_valid === 1'b1 && rsp_data === exp_status(1), "R10 queued request", rsp_data, exp_status(1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin
      m_sec[i] = 0; m_meta[i] = 0; m_grp[i] = 0; m_dead[i] = 1;
    end
    repeat (3) @(negedge clk);
    check(rsp_valid === 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check(req_ready === 1'b1, "R1 req_ready", 32'(req_ready), 1);
    for (int w = 0; w < 32; w++) do_op(2'd3, w, 0, 0, "R1 all spent");

    // R2 / R3 / R4
    do_op(2'd1, 5, 32'hCAFE_0005, 8'b01_10_1001, "R2 init");
    do_op(2'd3, 0, 0, 0, "R2 armed status");
    do_op(2'd0, 5, 0, 8'b01_10_1001, "R3 release");
    do_op(2'd0, 5, 0, 8'b01_10_1001, "R4 second read");
    do_op(2'd0, 5, 0, 8'b01_10_1001, "R4 third read");

    // R5: tag mismatch, then phase mismatch on a fresh cell
    do_op(2'd1, 6, 32'h1234_5678, 8'b11_00_0111, "R5 init");
    do_op(2'd0, 6, 0, 8'b11_00_0110, "R5 bad tag");
    do_op(2'd0, 6, 0, 8'b11_00_0111, "R5 spent after bad read");
    do_op(2'd1, 7, 32'h0BAD_F00D, 8'b00_01_0000, "R5 init b");
    do_op(2'd0, 7, 0, 8'b00_10_0000, "R5 bad phase");

    // R6 / R7: cells 10..12 in group 3, cell 13 unlinked
    for (int c = 10; c <= 12; c++) do_op(2'd2, c, 3, 0, "R6 group");
    for (int c = 10; c <= 13; c++) do_op(2'd1, c, 32'hA000_0000 + c, 8'(c), "R6 init");
    do_op(2'd0, 10, 0, 8'd10, "R6 trigger");
    do_op(2'd0, 11, 0, 8'd11, "R7 peer next clock");
    idle();
    do_op(2'd3, 0, 0, 0, "R6 group spent, unlinked armed");
    do_op(2'd0, 13, 0, 8'd13, "R6 group 0 unaffected");

    // R8
    do_op(2'd1, 10, 32'h5555_AAAA, 8'd44, "R8 re-arm one");
    do_op(2'd3, 0, 0, 0, "R8 peers stay spent");
    for (int c = 20; c <= 21; c++) do_op(2'd2, c, 5, 0, "R8 group");
    for (int c = 20; c <= 21; c++) do_op(2'd1, c, 32'hB000_0000 + c, 8'(c), "R8 init");
    do_op(2'd0, 20, 0, 8'd20, "R8 trigger");
    do_op(2'd1, 21, 32'hFEED_0021, 8'd99, "R8 init same clock as spread");
    do_op(2'd3, 0, 0, 0, "R8 init wins");
    do_op(2'd0, 21, 0, 8'd99, "R8 release after re-arm");

    bp_test();

    // Random mix over cells 0..47 with groups 0..3
    for (int it = 0; it < 4000; it++) begin
      int r, a;
      r = int'($urandom_range(9));
      a = int'($urandom_range(47));
      case (r)
        0, 1, 2, 3: do_op(2'd0, a, 0, ($urandom_range(3) != 0) ? m_meta[a] : 8'($urandom), "RND read R3 R5");
        4, 5:       do_op(2'd1, a, $urandom, 8'($urandom), "RND init R2");
        6:          do_op(2'd2, a, 32'($urandom_range(3)), 0, "RND group R6");
        7:          do_op(2'd3, int'($urandom_range(1)), 0, 0, "RND status R9");
        default:    idle();
      endcase
    end
    idle();
    do_op(2'd3, 0, 0, 0, "R9 final word 0");
    do_op(2'd3, 1, 0, 0, "R9 final word 1");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule